// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block is the status and control register that sits next to a floating-point datapath. After each completed arithmetic operation it records which IEEE exceptions that operation raised (the per-operation cause bits). It also folds them into sticky accumulated flags and compares the causes against per-exception enable bits. When a raised exception is enabled, it asks the core to take a trap. The register also decodes its own control fields into the rounding-mode and denormal-flush signals that steer the datapath.

Software writes the register through a load port and reads it through a read port. The datapath reports each completed operation with a strobe, five raw exception flags and an indicator that the operation was a reciprocal-square-root approximation. The block does no arithmetic of its own.

Top module: `fp_status_reg`

## Requirements
- R1: Reset clears the register to 0x00000000. A software load stores the load value ANDed with the writable mask 0x003FFFFF, so bits 31:22 always read 0. The new value shows on the read port in the cycle after the load strobe.
- R2: The register layout is: rounding mode in bits 1:0, sticky flags in bits 6:2, enables in bits 11:7, causes in bits 17:12, denormal control in bit 18, and plain stored bits in 21:19. The round-toward-zero output is high only while bits 1:0 hold 01. The codes 00, 10 and 11 all select round-to-nearest-even, which drives the output low.
- R3: The flush-to-zero output follows the denormal control bit 18.
- R4: The raw flags input is ordered {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0. On a completion strobe the whole cause field (bits 17:12) is cleared. Then cause bits 16..12 are set for invalid, divide-by-zero, overflow, underflow and inexact, in that order. Bit 17 is never set by an operation, even when software loaded it as 1.
- R5: After each operation the new cause bits are ORed into the flag field, which uses the same bit order (bit 6 invalid down to bit 2 inexact). Operations never clear a flag.
- R6: If a new cause bit meets its enable bit, the trap request pulses high for exactly one cycle. The enable bits use the same bit order (bit 11 invalid down to bit 7 inexact). The pulse comes in the cycle after the strobe, together with the updated register value, and the trap code 0x120. The trap code reads 0 whenever no trap is requested.
- R7: A completion that raises no flag still clears the cause field, leaves the flags as they were, and raises no trap.
- R8: An approximation operation that raises no flag counts as raising inexact (cause bit 12). If it raises any other flag, only the raised flags are recorded.
- R9: When a load and a completion strobe arrive in the same cycle, the load wins. The register takes the masked load value, the operation's exceptions are discarded, and no trap is requested.
- R10: With neither strobe high, the register keeps its value and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Value to load |
| rd_data | output | 32 | Current register contents |
| op_done | input | 1 | Completion strobe for one datapath operation |
| op_flags | input | 5 | Raw exception flags {V, Z, O, U, I} |
| op_approx | input | 1 | The completing operation is a reciprocal-square-root approximation |
| round_to_zero | output | 1 | 1 selects round-toward-zero, 0 selects round-to-nearest-even |
| flush_denorm | output | 1 | Flush-to-zero control for the datapath |
| trap_req | output | 1 | One-cycle floating-point trap request |
| trap_code | output | 12 | Exception code while trap_req is high, otherwise 0 |

## Verification
A software load and an operation completion can land in the same clock cycle. The bench provokes this by raising both strobes on one clock edge. In that cycle the completion carries an enabled flag, and the load value differs from what the operation would produce. The result counts as correct when the read port shows exactly the masked load value, with no cause from the operation in it and no trap pulse. The same scenario also loads the cause bit that operations never produce, and then checks that the next plain operation clears it.

// File: rtl/fpsr_pkg.sv
// Shared field positions, codes and types for the floating-point status register.
// Assumes a five-exception IEEE set and a two-bit rounding-mode field.
package fpsr_pkg;
    localparam int NEXC        = 5;
    localparam int RM_W        = 2;
    localparam int RM_LSB      = 0;
    localparam int FLAG_LSB    = 2;
    localparam int EN_LSB      = 7;
    localparam int CAUSE_LSB   = 12;
    localparam int CAUSE_W     = NEXC + 1;
    localparam int DN_BIT      = 18;
    localparam logic [RM_W-1:0] RM_TOWARD_ZERO = 2'b01;

    // Exception vector; inexact sits in the least significant bit.
    typedef struct packed {
        logic inv;
        logic dz;
        logic ovf;
        logic unf;
        logic inx;
    } exc_t;
endpackage

// File: rtl/fpsr_exc_gather.sv
// Turns the raw exception flags of one operation into the cause vector.
// An approximation result with no flag counts as inexact.
// Assumes the flags are valid whenever the completion strobe is high.
module fpsr_exc_gather
    import fpsr_pkg::*;
(
    input  exc_t raw_exc,
    input  logic approx,
    output exc_t cause
);
    // Force inexact for a silent approximation.
    always_comb begin
        cause = raw_exc;
        if (approx && (raw_exc == '0)) begin
            cause.inx = 1'b1;
        end
    end
endmodule

// File: rtl/fpsr_mode_decode.sv
// Decodes the rounding-mode field and the denormal bit into datapath controls.
// Assumes only one rounding code selects toward-zero; every other code means nearest-even.
module fpsr_mode_decode
    import fpsr_pkg::*;
(
    input  logic [RM_W-1:0] rm_field,
    input  logic            dn_bit,
    output logic            rtz,
    output logic            ftz
);
    // Map the stored fields to datapath control levels.
    always_comb begin
        rtz = (rm_field == RM_TOWARD_ZERO);
        ftz = dn_bit;
    end
endmodule

// File: rtl/fpsr_next_state.sv
// Computes the next register value and the trap decision for one cycle.
// A load has priority over a completion. A completion rebuilds the cause field,
// accumulates the flags and tests the causes against the enables.
// Assumes the strobes are single-cycle qualifiers.
module fpsr_next_state
    import fpsr_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h003F_FFFF
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              op_done,
    input  exc_t              cause,
    output logic [DATA_W-1:0] nxt,
    output logic              trap
);
    // Select between hold, masked load and exception update.
    always_comb begin
        nxt  = cur;
        trap = 1'b0;
        if (ld_en) begin
            nxt = ld_data & WR_MASK;
        end else if (op_done) begin
            nxt[CAUSE_LSB +: CAUSE_W] = '0;
            nxt[CAUSE_LSB +: NEXC]    = cause;
            nxt[FLAG_LSB +: NEXC]     = cur[FLAG_LSB +: NEXC] | cause;
            trap = |(cause & cur[EN_LSB +: NEXC]);
        end
    end
endmodule

// File: rtl/fp_status_reg.sv
// Floating-point status/control register with exception capture and trap request.
// Holds the register, registers the trap pulse and drives the decoded controls.
// Assumes a synchronous active-low reset and one completion per cycle at most.
module fp_status_reg
    import fpsr_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] WR_MASK   = 32'h003F_FFFF,
    parameter logic [DATA_W-1:0] RESET_VAL = '0,
    parameter int                CODE_W    = 12,
    parameter logic [CODE_W-1:0] EXC_CODE  = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              op_done,
    input  logic [NEXC-1:0]   op_flags,
    input  logic              op_approx,
    output logic              round_to_zero,
    output logic              flush_denorm,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] reg_d;
    logic              trap_d;
    logic              trap_q;
    exc_t              cause;

    fpsr_exc_gather u_gather (
        .raw_exc (exc_t'(op_flags)),
        .approx  (op_approx),
        .cause   (cause)
    );

    fpsr_next_state #(
        .DATA_W  (DATA_W),
        .WR_MASK (WR_MASK)
    ) u_next (
        .cur     (reg_q),
        .ld_en   (ld_en),
        .ld_data (ld_data),
        .op_done (op_done),
        .cause   (cause),
        .nxt     (reg_d),
        .trap    (trap_d)
    );

    fpsr_mode_decode u_mode (
        .rm_field (reg_q[RM_LSB +: RM_W]),
        .dn_bit   (reg_q[DN_BIT]),
        .rtz      (round_to_zero),
        .ftz      (flush_denorm)
    );

    // Register state and the one-cycle trap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q  <= RESET_VAL & WR_MASK;
            trap_q <= 1'b0;
        end else begin
            reg_q  <= reg_d & WR_MASK;
            trap_q <= trap_d;
        end
    end

    // Drive the read port and the trap code.
    always_comb begin
        rd_data   = reg_q;
        trap_req  = trap_q;
        trap_code = trap_q ? EXC_CODE : '0;
    end
endmodule

// File: rtl/fpsr_checks.sv
// Temporal checks for fp_status_reg, attached with bind.
// Assumes the default field layout from fpsr_pkg.
module fpsr_checks
    import fpsr_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] WR_MASK = 32'h003F_FFFF,
    parameter int                CODE_W  = 12,
    parameter logic [CODE_W-1:0] EXC_CODE = 12'h120
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [DATA_W-1:0] ld_data,
    input logic              op_done,
    input logic [DATA_W-1:0] rd_data,
    input logic              round_to_zero,
    input logic              flush_denorm,
    input logic              trap_req,
    input logic [CODE_W-1:0] trap_code
);
    AST_UNWRITABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~WR_MASK) == '0); // R1
    AST_LOAD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> rd_data == ($past(ld_data) & WR_MASK)); // R1
    AST_RTZ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        round_to_zero == (rd_data[RM_LSB +: RM_W] == RM_TOWARD_ZERO)); // R2
    AST_FTZ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        flush_denorm == rd_data[DN_BIT]); // R3
    AST_E_CAUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !ld_en) |=> !rd_data[CAUSE_LSB + NEXC]); // R4
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !ld_en) |=> (rd_data[FLAG_LSB +: NEXC] & $past(rd_data[FLAG_LSB +: NEXC]))
                                 == $past(rd_data[FLAG_LSB +: NEXC])); // R5
    AST_TRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_code == EXC_CODE); // R6
    AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> $past(op_done && !ld_en)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !op_done) |=> ($stable(rd_data) && !trap_req)); // R10
endmodule

bind fp_status_reg fpsr_checks #(
    .DATA_W   (DATA_W),
    .WR_MASK  (WR_MASK),
    .CODE_W   (CODE_W),
    .EXC_CODE (EXC_CODE)
) u_fpsr_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_en         (ld_en),
    .ld_data       (ld_data),
    .op_done       (op_done),
    .rd_data       (rd_data),
    .round_to_zero (round_to_zero),
    .flush_denorm  (flush_denorm),
    .trap_req      (trap_req),
    .trap_code     (trap_code)
);

// File: tb/fp_status_reg_bench.sv
module fp_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] rd_data;
    logic        op_done = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        op_approx = 1'b0;
    logic        round_to_zero;
    logic        flush_denorm;
    logic        trap_req;
    logic [11:0] trap_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] model = '0;

    always #10 clk = ~clk;

    fp_status_reg u_fp_status_reg (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data), .rd_data(rd_data),
        .op_done(op_done), .op_flags(op_flags), .op_approx(op_approx),
        .round_to_zero(round_to_zero), .flush_denorm(flush_denorm),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of one completion: layout from R2, cause rules from R4, R5, R7, R8.
    function automatic logic [31:0] apply_op(input logic [31:0] r, input logic [4:0] f,
                                             input logic ap, output logic trap);
        logic [4:0] c;
        logic [31:0] n;
        c = f;
        if (ap && f == 5'b0) c = 5'b00001;
        n = r;
        n[17:12] = {1'b0, c};
        n[6:2] = r[6:2] | c;
        trap = |(c & r[11:7]);
        return n;
    endfunction

    task automatic do_load(input logic [31:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        model = v & 32'h003F_FFFF;
    endtask

    // Runs one completion and checks value, trap and trap code.
    task automatic do_op(input string req, input logic [4:0] f, input logic ap);
        logic t;
        @(negedge clk);
        op_done = 1'b1; op_flags = f; op_approx = ap;
        @(negedge clk);
        op_done = 1'b0; op_flags = '0; op_approx = 1'b0;
        model = apply_op(model, f, ap, t);
        chk(req, rd_data, model);
        chk({req, " trap"}, {31'b0, trap_req}, {31'b0, t});
        chk({req, " code"}, {20'b0, trap_code}, t ? 32'h120 : 32'h0);
        @(negedge clk);
        chk({req, " pulse end"}, {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_reset;
        chk("R1 reset value", rd_data, 32'h0);
        chk("R10 reset trap", {31'b0, trap_req}, 32'h0);
        chk("R2 reset rounding", {31'b0, round_to_zero}, 32'h0);
    endtask

    task automatic t_load_mask;
        do_load(32'hFFFF_FFFF);
        chk("R1 masked load", rd_data, 32'h003F_FFFF);
        chk("R3 flush set", {31'b0, flush_denorm}, 32'h1);
        chk("R2 code 11 nearest", {31'b0, round_to_zero}, 32'h0);
    endtask

    task automatic t_rounding;
        do_load(32'h0000_0001);
        chk("R2 code 01 zero", {31'b0, round_to_zero}, 32'h1);
        chk("R3 flush clear", {31'b0, flush_denorm}, 32'h0);
        do_load(32'h0000_0002);
        chk("R2 code 10 nearest", {31'b0, round_to_zero}, 32'h0);
        do_load(32'h0000_0000);
        chk("R2 code 00 nearest", {31'b0, round_to_zero}, 32'h0);
    endtask

    task automatic t_causes;
        do_load(32'h0000_0000);
        do_op("R4 invalid cause", 5'b10000, 1'b0);
        do_op("R5 overflow accumulates", 5'b00100, 1'b0);
        do_op("R7 no flags clears cause", 5'b00000, 1'b0);
        do_op("R4 under+inexact", 5'b00011, 1'b0);
    endtask

    task automatic t_trap;
        do_load(32'h0000_0400);
        do_op("R6 enabled divzero traps", 5'b01000, 1'b0);
        do_op("R6 disabled overflow no trap", 5'b00100, 1'b0);
        do_load(32'h0000_0F80);
        do_op("R7 empty op no trap", 5'b00000, 1'b0);
    endtask

    task automatic t_approx;
        do_load(32'h0000_0080);
        do_op("R8 approx forces inexact", 5'b00000, 1'b1);
        do_load(32'h0000_0000);
        do_op("R8 approx with underflow", 5'b00010, 1'b1);
    endtask

    task automatic t_collision;
        do_load(32'h0002_0FFC);
        do_op("R4 E cause cleared", 5'b00000, 1'b0);
        @(negedge clk);
        ld_en = 1'b1; ld_data = 32'hA002_0800; op_done = 1'b1; op_flags = 5'b10000;
        @(negedge clk);
        ld_en = 1'b0; op_done = 1'b0; op_flags = '0;
        model = 32'h0002_0800;
        chk("R9 load wins", rd_data, model);
        chk("R9 no trap", {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_idle;
        repeat (3) @(negedge clk);
        chk("R10 hold", rd_data, model);
        chk("R10 idle no trap", {31'b0, trap_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_mask();
        t_rounding();
        t_causes();
        t_trap();
        t_approx();
        t_collision();
        t_idle();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule